// File: doc/BRIEF.md
# Pulse-Width Bit Codec for a Clock-Embedded Single-Wire Bus

This block is the digital codec of a node on a single-wire bus that carries its own clock. Every bit period opens with a falling edge on the bus. The width of the low phase that follows gives the bit value: a short low is a logical 1 and a longer low is a logical 0. On the transmit side the block takes the serial byte stream from the host's UART output (`txd_in`) and re-times it onto the bus, one bit per bit period. On the receive side it measures how long the bus stays low in each period and returns the decoded bit to the host on `rxd_out`. All timing is counted in ticks of the sample clock `clk`.

In the master role the bit period comes from an external bit clock (`bitclk_in`). Each falling edge of that clock starts a bus pulse. When no data is sent the master keeps emitting logical-1 pulses, so the bus clock never stops. In the slave role the bit period is taken from the falling edges of the bus itself. A slave signals a 0 by stretching the low phase and leaves the bus alone for a 1. It also rebuilds the bit clock on `clk_out`.

When codec mode is entered, the block first learns the low width of a logical 1 over a fixed number of bit periods. While it learns, transmit and receive are held off. After that, the decision threshold is the learned width plus a fixed margin. Transmit latency is fixed at two bit periods and receive latency at one.

Top module: `pwm_bit_codec`

## Requirements
- R1: While `rst` is high or `codec_en` is low, the outputs sit in their quiet state one cycle later: `bus_tx`=1 (released), `rxd_out`=1, `clk_oe`=0 and `clk_out`=1.
- R2: In the master role, the bit boundary is the falling edge of `bitclk_in` after `SYNC_STAGES` synchronizer flops. At each boundary `bus_tx` goes to 0 (pull low) for exactly `LOW1_TICKS` cycles to send a 1, or `LOW0_TICKS` cycles to send a 0. The first pulse appears in the first bit period after `codec_en` rises, which is well inside six bit periods.
- R3: The level of `txd_in` sampled at bit boundary k is the bit sent in bit period k+2, once learning has ended.
- R4: For the first `LEARN_BITS` boundaries after `codec_en` rises, the block sends logical 1s whatever `txd_in` holds, and `rxd_out` stays 1.
- R5: The low width of each bus bit is counted in `clk` cycles. During learning, that width is stored as the learned logical-1 width. After learning, a width greater than the learned width plus `MARGIN_TICKS` decodes as 0 and any other width decodes as 1. The decoded bit appears on `rxd_out` at the next bit boundary and holds for one bit period.
- R6: In the slave role, the bit boundary is a synchronized falling edge of `bus_in`. A 0 is sent as `LOW0_TICKS` cycles of `bus_tx`=0 from that boundary. A 1 leaves `bus_tx`=1.
- R7: In the slave role while active, `clk_oe`=1. After each boundary, `clk_out` is low for half of the period measured between the last two boundaries and is high for the rest of the period.
- R8: In the master role, `clk_oe`=0 and `clk_out`=1.
- R9: A run of `bus_tx`=0 never lasts longer than `LOW0_TICKS` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| codec_en | input | 1 | 1 = codec mode active; 0 = idle and cleared |
| master_role | input | 1 | 1 = master (bit clock from `bitclk_in`), 0 = slave (bit clock from the bus) |
| bitclk_in | input | 1 | External bit clock, used in the master role |
| txd_in | input | 1 | Serial data to send, from the host |
| bus_in | input | 1 | Sampled bus level (1 = high) |
| bus_tx | output | 1 | Bus drive: 0 = pull low, 1 = release |
| rxd_out | output | 1 | Decoded serial data to the host |
| clk_out | output | 1 | Recovered bit clock in the slave role, 1 otherwise |
| clk_oe | output | 1 | Output enable for `clk_out`; 0 means released |

## Verification
The two functions that share cycles are the block's own transmit drive and its receive width measurement. On the wired-AND bus, this node's pulse and the other node's pulse overlap inside the same low phase, so the measured width is the union of the two. In both roles the bench plays the opposite node and drives a random mix of short and long lows against random `txd_in` data. It also runs directed all-zero and alternating stretches. It then judges `rxd_out` against the AND of both nodes' bits and judges the drive length on `bus_tx` against this node's bit alone. The learning boundary is a second meeting point: the boundary at which learning ends also starts a pulse. The bench checks that pulse against `txd_in` values that were sampled while learning was still under way.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // level and one-cycle edge flags of a synchronized input
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_t;

endpackage

// File: rtl/pwc_sync.sv
module pwc_sync
  import pwc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  din,
  output edge_t ev
);

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  always_comb begin
    ev.level = chain[STAGES-1];
    ev.fall  = prev & ~chain[STAGES-1];
    ev.rise  = ~prev & chain[STAGES-1];
  end

endmodule

// File: rtl/pwc_tx.sv
module pwc_tx #(
  parameter int CNT_W      = 12,
  parameter int LOW1_TICKS = 20,
  parameter int LOW0_TICKS = 40,
  parameter int TX_DEPTH   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic master,
  input  logic strobe,
  input  logic ready,
  input  logic txd_bit,
  output logic bus_tx
);

  localparam logic [CNT_W-1:0] L1M = CNT_W'(LOW1_TICKS - 1);
  localparam logic [CNT_W-1:0] L0M = CNT_W'(LOW0_TICKS - 1);

  logic [TX_DEPTH-1:0] pipe;
  logic [CNT_W-1:0]    cnt;
  logic                send_bit;
  logic                start;

  // before learning ends only ones go out
  always_comb begin
    send_bit = ready ? pipe[TX_DEPTH-1] : 1'b1;
    start    = strobe && (master || !send_bit);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pipe   <= '1;
      cnt    <= '0;
      bus_tx <= 1'b1;
    end else begin
      if (strobe) pipe <= {pipe[TX_DEPTH-2:0], txd_bit};
      if (start) begin
        bus_tx <= 1'b0;
        cnt    <= send_bit ? L1M : L0M;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        bus_tx <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwc_rx.sv
module pwc_rx #(
  parameter int CNT_W        = 12,
  parameter int MARGIN_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ready,
  input  logic strobe,
  input  logic bus_level,
  input  logic bus_fall,
  input  logic bus_rise,
  output logic rxd_out
);

  localparam logic [CNT_W-1:0] WMAX = '1;

  logic [CNT_W-1:0] wcnt;
  logic [CNT_W-1:0] learned;
  logic [CNT_W:0]   thresh;
  logic             rx_bit;

  always_comb thresh = {1'b0, learned} + (CNT_W+1)'(MARGIN_TICKS);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      wcnt    <= '0;
      learned <= '0;
      rx_bit  <= 1'b1;
      rxd_out <= 1'b1;
    end else begin
      if (bus_fall)                        wcnt <= CNT_W'(1);
      else if (!bus_level && wcnt != WMAX) wcnt <= wcnt + 1'b1;

      if (bus_rise) begin
        if (!ready) learned <= wcnt;
        else        rx_bit  <= ({1'b0, wcnt} > thresh) ? 1'b0 : 1'b1;
      end

      if (strobe && ready) rxd_out <= rx_bit;
    end
  end

endmodule

// File: rtl/pwc_clkrec.sv
module pwc_clkrec #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic strobe,
  output logic clk_out,
  output logic clk_oe
);

  localparam logic [CNT_W-1:0] PMAX = '1;

  logic [CNT_W-1:0] pcnt;
  logic [CNT_W-1:0] hcnt;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] half;
  logic             valid;

  always_comb begin
    period = {1'b0, pcnt} + 1'b1;
    half   = period[CNT_W:1];
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pcnt    <= '0;
      hcnt    <= '0;
      valid   <= 1'b0;
      clk_out <= 1'b1;
      clk_oe  <= 1'b0;
    end else begin
      clk_oe <= 1'b1;
      if (strobe) begin
        valid <= 1'b1;
        pcnt  <= '0;
        if (valid && half != '0) begin
          clk_out <= 1'b0;
          hcnt    <= half - 1'b1;
        end
      end else begin
        if (pcnt != PMAX) pcnt <= pcnt + 1'b1;
        if (hcnt != '0)   hcnt <= hcnt - 1'b1;
        else              clk_out <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_bit_codec.sv
module pwm_bit_codec
  import pwc_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 12,
  parameter int LOW1_TICKS   = 20,
  parameter int LOW0_TICKS   = 40,
  parameter int MARGIN_TICKS = 10,
  parameter int LEARN_BITS   = 16,
  parameter int TX_DEPTH     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic codec_en,
  input  logic master_role,
  input  logic bitclk_in,
  input  logic txd_in,
  input  logic bus_in,
  output logic bus_tx,
  output logic rxd_out,
  output logic clk_out,
  output logic clk_oe
);

  localparam int BC_W = $clog2(LEARN_BITS + 1);
  localparam logic [BC_W-1:0] LEARN_END = BC_W'(LEARN_BITS);

  edge_t bclk_ev, bus_ev, txd_ev;
  logic  strobe;
  logic  learn_done;
  logic  [BC_W-1:0] bitcnt;
  logic  unused_edges;

  pwc_sync #(.STAGES(SYNC_STAGES)) u_sync_bclk (.clk(clk), .rst(rst), .din(bitclk_in), .ev(bclk_ev));
  pwc_sync #(.STAGES(SYNC_STAGES)) u_sync_bus  (.clk(clk), .rst(rst), .din(bus_in),    .ev(bus_ev));
  pwc_sync #(.STAGES(SYNC_STAGES)) u_sync_txd  (.clk(clk), .rst(rst), .din(txd_in),    .ev(txd_ev));

  assign unused_edges = ^{bclk_ev.level, bclk_ev.rise, txd_ev.rise, txd_ev.fall};

  // bit boundary source depends on role
  always_comb strobe = codec_en && (master_role ? bclk_ev.fall : bus_ev.fall);
  always_comb learn_done = (bitcnt == LEARN_END);

  always_ff @(posedge clk) begin
    if (rst || !codec_en)           bitcnt <= '0;
    else if (strobe && !learn_done) bitcnt <= bitcnt + 1'b1;
  end

  pwc_tx #(
    .CNT_W(CNT_W), .LOW1_TICKS(LOW1_TICKS), .LOW0_TICKS(LOW0_TICKS), .TX_DEPTH(TX_DEPTH)
  ) u_tx (
    .clk(clk), .rst(rst), .active(codec_en), .master(master_role), .strobe(strobe),
    .ready(learn_done), .txd_bit(txd_ev.level), .bus_tx(bus_tx)
  );

  pwc_rx #(
    .CNT_W(CNT_W), .MARGIN_TICKS(MARGIN_TICKS)
  ) u_rx (
    .clk(clk), .rst(rst), .active(codec_en), .ready(learn_done), .strobe(strobe),
    .bus_level(bus_ev.level), .bus_fall(bus_ev.fall), .bus_rise(bus_ev.rise), .rxd_out(rxd_out)
  );

  pwc_clkrec #(
    .CNT_W(CNT_W)
  ) u_clkrec (
    .clk(clk), .rst(rst), .enable(codec_en && !master_role), .strobe(strobe),
    .clk_out(clk_out), .clk_oe(clk_oe)
  );

endmodule

// File: rtl/pwm_bit_codec_chk.sv
module pwm_bit_codec_chk #(
  parameter int CNT_W      = 12,
  parameter int LOW1_TICKS = 20,
  parameter int LOW0_TICKS = 40
) (
  input logic clk,
  input logic rst,
  input logic codec_en,
  input logic master_role,
  input logic bus_tx,
  input logic rxd_out,
  input logic clk_out,
  input logic clk_oe,
  input logic learn_done
);

  logic [CNT_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)                run <= '0;
    else if (!bus_tx)       run <= (run == '1) ? run : run + 1'b1;
    else                    run <= '0;
  end

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst) !codec_en |=> (bus_tx && rxd_out && !clk_oe && clk_out)); // R1
  AST_LOW_RUN_MAX: assert property (@(posedge clk) disable iff (rst) run <= CNT_W'(LOW0_TICKS)); // R9
  AST_LEARN_SHORT: assert property (@(posedge clk) disable iff (rst) (codec_en && $past(codec_en) && master_role && !learn_done) |-> run <= CNT_W'(LOW1_TICKS)); // R4
  AST_SLAVE_QUIET_LEARN: assert property (@(posedge clk) disable iff (rst) (codec_en && $past(codec_en) && !master_role && !learn_done) |-> bus_tx); // R4
  AST_RXD_LEARN: assert property (@(posedge clk) disable iff (rst) !learn_done |-> rxd_out); // R4
  AST_MASTER_NO_CLK: assert property (@(posedge clk) disable iff (rst) master_role |=> (!clk_oe && clk_out)); // R8

endmodule

bind pwm_bit_codec pwm_bit_codec_chk #(
  .CNT_W(CNT_W), .LOW1_TICKS(LOW1_TICKS), .LOW0_TICKS(LOW0_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .codec_en(codec_en), .master_role(master_role), .bus_tx(bus_tx),
  .rxd_out(rxd_out), .clk_out(clk_out), .clk_oe(clk_oe), .learn_done(learn_done)
);

// File: tb/pwm_bit_codec_test.sv
module pwm_bit_codec_test;

  localparam int BIT   = 100;
  localparam int NB    = 70;
  localparam int LOW1  = 20;
  localparam int LOW0  = 40;
  localparam int LEARN = 16;

  logic clk = 1'b0;
  logic rst, codec_en, master_role, bitclk_in, txd_in, bench_pull;
  logic bus_in, bus_tx, rxd_out, clk_out, clk_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  bit tx_b [NB+2];
  bit bn_b [NB];
  int low_rec [NB];
  int clk_rec [NB];
  bit rx_rec [NB];
  int oe_bad;

  always #2 clk = ~clk;

  assign bus_in = bus_tx & ~bench_pull;

  pwm_bit_codec #(
    .SYNC_STAGES(2), .CNT_W(12), .LOW1_TICKS(LOW1), .LOW0_TICKS(LOW0),
    .MARGIN_TICKS(10), .LEARN_BITS(LEARN), .TX_DEPTH(2)
  ) uut (
    .clk(clk), .rst(rst), .codec_en(codec_en), .master_role(master_role),
    .bitclk_in(bitclk_in), .txd_in(txd_in), .bus_in(bus_in), .bus_tx(bus_tx),
    .rxd_out(rxd_out), .clk_out(clk_out), .clk_oe(clk_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit this node sends in period k
  function automatic bit node_bit(input int k);
    return (k < LEARN) ? 1'b1 : tx_b[k-2];
  endfunction

  function automatic int exp_low(input bit mst, input bit b);
    if (mst) return b ? LOW1 : LOW0;
    return b ? 0 : LOW0;
  endfunction

  task automatic quiet_check(input string tag);
    chk({tag, " R1 bus_tx"},  int'(bus_tx),  1);
    chk({tag, " R1 rxd_out"}, int'(rxd_out), 1);
    chk({tag, " R1 clk_oe"},  int'(clk_oe),  0);
    chk({tag, " R1 clk_out"}, int'(clk_out), 1);
  endtask

  task automatic run_phase(input bit mst);
    int maxlow = 0;
    for (int k = 0; k < NB + 2; k++) tx_b[k] = 1'($urandom_range(0, 1));
    for (int k = 0; k < NB; k++) bn_b[k] = (k < LEARN) ? 1'b1 : 1'($urandom_range(0, 1));
    for (int k = 20; k < 28; k++) tx_b[k] = 1'b0;          // long zero run
    for (int k = 30; k < 38; k++) bn_b[k] = 1'b0;          // other node all zeros
    for (int k = 40; k < 48; k++) tx_b[k] = 1'(k % 2);     // alternating
    tx_b[14] = 1'b0;                                        // sampled during learning, sent at 16
    @(negedge clk);
    master_role = mst;
    txd_in = tx_b[0];
    bitclk_in = 1'b1;
    bench_pull = 1'b0;
    @(negedge clk);
    codec_en = 1'b1;
    repeat (3) @(negedge clk);
    oe_bad = 0;
    for (int k = 0; k < NB; k++) begin
      low_rec[k] = 0;
      clk_rec[k] = 0;
      for (int j = 0; j < BIT; j++) begin
        @(negedge clk);
        bitclk_in = mst ? (j < 50 ? 1'b0 : 1'b1) : 1'b1;
        if (mst) bench_pull = !bn_b[k] && j >= 1 && j < 46;
        else     bench_pull = (j < (bn_b[k] ? LOW1 : LOW0));
        if (j == 60) txd_in = tx_b[k+1];
        if (!bus_tx) low_rec[k]++;
        if (!clk_out) clk_rec[k]++;
        if (clk_oe != !mst) oe_bad++;
        if (j == 80) rx_rec[k] = rxd_out;
      end
    end
    bitclk_in = 1'b1;
    bench_pull = 1'b0;
    for (int k = 0; k < NB; k++) begin
      string req;
      req = (k < LEARN) ? "R4 tx" : (mst ? "R3 R2" : "R3 R6");
      chk(req, low_rec[k], exp_low(mst, node_bit(k)));
      if (low_rec[k] > maxlow) maxlow = low_rec[k];
    end
    if (mst) chk("R2 first pulse", low_rec[0], LOW1);
    chk("R9 max low run", int'(maxlow <= LOW0), 1);
    for (int k = 1; k < NB; k++) begin
      if (k <= LEARN) chk("R4 rxd", int'(rx_rec[k]), 1);
      else chk("R5 rxd", int'(rx_rec[k]), int'(node_bit(k-1) & bn_b[k-1]));
    end
    if (mst) begin
      for (int k = 0; k < NB; k++) chk("R8 clk_out", clk_rec[k], 0);
      chk("R8 clk_oe", oe_bad, 0);
    end else begin
      for (int k = 2; k < NB; k++) chk("R7 clk_out low", clk_rec[k], BIT / 2);
      chk("R7 clk_oe", oe_bad, 0);
    end
    @(negedge clk);
    codec_en = 1'b0;
    repeat (2) @(negedge clk);
    quiet_check(mst ? "master exit" : "slave exit");
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst = 1'b1;
    codec_en = 1'b0;
    master_role = 1'b1;
    bitclk_in = 1'b1;
    txd_in = 1'b1;
    bench_pull = 1'b0;
    repeat (4) @(negedge clk);
    quiet_check("reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    quiet_check("idle");
    run_phase(1'b1);
    repeat (5) @(negedge clk);
    run_phase(1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule